// File: doc/BRIEF.md
# Push-Button Voice Recorder Sequencer

This controller runs a single-message recorder from three active-low push buttons: one for record, one that starts playback on its press, and one that plays only while it is held down. It walks a linear address counter across a fixed message space, advancing one location per step tick. Each step drives a write or read strobe toward an external storage array. The controller keeps its own one-bit-per-location end-marker store. Record ends with a marker written at the first unwritten location, or with the space full. Playback ends at a marker, at the last location, or when the held button is let go. When nothing is running, the block raises its power-down output.

The buttons are assumed debounced and synchronous to `clk`. The storage depth `DEPTH` and the step divider `TICK_DIV` are parameters. `DEPTH` must be a power of two and `TICK_DIV` at least 2. The step tick is free running: it fires on every `TICK_DIV`-th clock after reset, whatever the controller is doing.

Top module: `pbrec_ctrl`

## Requirements
- R1: After reset the block is idle. `pwr_dn_o`=1, `rec_led_n_o`=1, `addr_o`=0, all strobes are 0 and every end marker is clear.
- R2: A press of the record button (1→0 on `rec_n`) starts recording at address 0 from any state, including in the middle of playback. From the next cycle `rec_led_n_o`=0 and `pwr_dn_o`=0.
- R3: While recording, each step tick gives one `wr_stb_o` pulse. `addr_o` is 0 on the first pulse and rises by one on each later pulse. The same step clears the marker at that address.
- R4: Releasing record before the space is full gives one `mark_wr_o` pulse with `addr_o` equal to the first unwritten address. It sets that marker and makes the block idle in the same cycle.
- R5: After the write at `DEPTH-1`, recording stops and `rec_led_n_o` returns to 1. `pwr_dn_o` stays 0 and no marker is written. Releasing the button then makes the block idle.
- R6: A press of the edge-play button starts playback at address 0 from idle or from any playback. Releasing that button has no effect. A later press restarts playback at address 0.
- R7: A press of the level-play button starts playback at address 0 from idle. Releasing that button during this playback makes the block idle on the next cycle.
- R8: During playback, each step tick gives one `rd_stb_o` pulse at increasing addresses from 0. If the location read holds a marker, `eom_o` pulses with that read and the block goes idle. After the read at `DEPTH-1` it goes idle without `eom_o`.
- R9: Play-button presses are ignored while recording or while waiting for release after a full record.
- R10: When presses arrive in the same cycle, record wins over edge-play, and edge-play wins over level-play. A playback started that way then ignores the level-play button.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_n | input | 1 | Record button, active low |
| play_edge_n | input | 1 | Press-to-start play button, active low |
| play_lvl_n | input | 1 | Hold-to-play button, active low |
| addr_o | output | $clog2(DEPTH) | Address of the latest strobe |
| wr_stb_o | output | 1 | One-cycle storage write strobe |
| rd_stb_o | output | 1 | One-cycle storage read strobe |
| mark_wr_o | output | 1 | One-cycle pulse when an end marker is written |
| eom_o | output | 1 | One-cycle pulse when playback reads a marker |
| rec_led_n_o | output | 1 | Record indicator, low while recording |
| pwr_dn_o | output | 1 | High while idle |

## Verification
The properties assume the buttons change only between clock edges and that no button is low while reset is released. Under those conditions, a press seen after reset is always a real 1→0 transition. The stimulus changes inputs just after the falling edge and holds every button high during reset. A press is given only at a chosen point, for example after a counted number of strobes. This keeps the release before the next step tick, so the marker address is deterministic.

// File: rtl/pbrec_pkg.sv
package pbrec_pkg;
    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,
        M_REC   = 3'd1,
        M_FULL  = 3'd2,
        M_PLAYE = 3'd3,
        M_PLAYL = 3'd4
    } mode_e;

    localparam int BTN_REC  = 0;
    localparam int BTN_EDGE = 1;
    localparam int BTN_LVL  = 2;
    localparam int NBTN     = 3;
endpackage

// File: rtl/pbrec_tick.sv
module pbrec_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == TOP) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == TOP);
endmodule

// File: rtl/pbrec_falls.sv
module pbrec_falls #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] btn_n,
    output logic [N-1:0] press_o
);
    for (genvar i = 0; i < N; i++) begin : g_btn
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= btn_n[i];
        end
        assign press_o[i] = prev_q & ~btn_n[i];
    end
endmodule

// File: rtl/pbrec_marks.sv
module pbrec_marks #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wbit,
    input  logic [AW-1:0] raddr,
    output logic          rbit
);
    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bits_q <= '0;
        else if (we) bits_q[waddr] <= wbit;
    end

    assign rbit = bits_q[raddr];
endmodule

// File: rtl/pbrec_ctrl.sv
module pbrec_ctrl
    import pbrec_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int TICK_DIV = 4,
    parameter int AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_n,
    input  logic          play_edge_n,
    input  logic          play_lvl_n,
    output logic [AW-1:0] addr_o,
    output logic          wr_stb_o,
    output logic          rd_stb_o,
    output logic          mark_wr_o,
    output logic          eom_o,
    output logic          rec_led_n_o,
    output logic          pwr_dn_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        mode_e         mode;
        logic [AW-1:0] addr;
        logic [AW-1:0] oaddr;
        logic          wr;
        logic          rd;
        logic          mw;
        logic          eom;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            tick;
    logic [NBTN-1:0] press;
    logic            mk_we, mk_wbit, mk_rbit;

    pbrec_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    pbrec_falls #(.N(NBTN)) u_falls (
        .clk(clk), .rst_n(rst_n),
        .btn_n({play_lvl_n, play_edge_n, rec_n}),
        .press_o(press)
    );

    pbrec_marks #(.DEPTH(DEPTH), .AW(AW)) u_marks (
        .clk(clk), .rst_n(rst_n),
        .we(mk_we), .waddr(ctl_q.addr), .wbit(mk_wbit),
        .raddr(ctl_q.addr), .rbit(mk_rbit)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.wr  = 1'b0;
        ctl_d.rd  = 1'b0;
        ctl_d.mw  = 1'b0;
        ctl_d.eom = 1'b0;
        mk_we     = 1'b0;
        mk_wbit   = 1'b0;
        if (press[BTN_REC]) begin
            ctl_d.mode = M_REC;
            ctl_d.addr = '0;
        end else begin
            case (ctl_q.mode)
                M_REC: begin
                    if (rec_n) begin
                        mk_we       = 1'b1;
                        mk_wbit     = 1'b1;
                        ctl_d.mw    = 1'b1;
                        ctl_d.oaddr = ctl_q.addr;
                        ctl_d.mode  = M_IDLE;
                    end else if (tick) begin
                        mk_we       = 1'b1;
                        ctl_d.wr    = 1'b1;
                        ctl_d.oaddr = ctl_q.addr;
                        if (ctl_q.addr == LAST) ctl_d.mode = M_FULL;
                        else                    ctl_d.addr = ctl_q.addr + 1'b1;
                    end
                end
                M_FULL: begin
                    if (rec_n) ctl_d.mode = M_IDLE;
                end
                default: begin
                    if (press[BTN_EDGE]) begin
                        ctl_d.mode = M_PLAYE;
                        ctl_d.addr = '0;
                    end else if (ctl_q.mode == M_IDLE && press[BTN_LVL]) begin
                        ctl_d.mode = M_PLAYL;
                        ctl_d.addr = '0;
                    end else if (ctl_q.mode == M_PLAYL && play_lvl_n) begin
                        ctl_d.mode = M_IDLE;
                    end else if (ctl_q.mode != M_IDLE && tick) begin
                        ctl_d.rd    = 1'b1;
                        ctl_d.oaddr = ctl_q.addr;
                        if (mk_rbit) begin
                            ctl_d.eom  = 1'b1;
                            ctl_d.mode = M_IDLE;
                        end else if (ctl_q.addr == LAST) begin
                            ctl_d.mode = M_IDLE;
                        end else begin
                            ctl_d.addr = ctl_q.addr + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mode <= M_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign addr_o      = ctl_q.oaddr;
    assign wr_stb_o    = ctl_q.wr;
    assign rd_stb_o    = ctl_q.rd;
    assign mark_wr_o   = ctl_q.mw;
    assign eom_o       = ctl_q.eom;
    assign rec_led_n_o = (ctl_q.mode != M_REC);
    assign pwr_dn_o    = (ctl_q.mode == M_IDLE);
endmodule

// File: rtl/pbrec_chk.sv
module pbrec_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb_o,
    input logic rd_stb_o,
    input logic mark_wr_o,
    input logic eom_o,
    input logic rec_led_n_o,
    input logic pwr_dn_o
);
    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb_o, rd_stb_o, mark_wr_o}));

    // R2
    rec_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_led_n_o |-> !pwr_dn_o);

    // R3
    wr_after_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> $past(!rec_led_n_o));

    // R4
    mark_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_wr_o |-> (pwr_dn_o && rec_led_n_o));

    // R8
    eom_with_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eom_o |-> rd_stb_o);

    // R8
    eom_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eom_o |-> pwr_dn_o);

    // R9
    rd_not_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_o |-> rec_led_n_o);
endmodule

bind pbrec_ctrl pbrec_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o),
    .mark_wr_o(mark_wr_o), .eom_o(eom_o),
    .rec_led_n_o(rec_led_n_o), .pwr_dn_o(pwr_dn_o)
);

// File: tb/sim_pbrec_ctrl.sv
module sim_pbrec_ctrl;
    localparam int D      = 16;
    localparam int TK     = 3;
    localparam int AW     = $clog2(D);
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_n = 1'b1, pe_n = 1'b1, pl_n = 1'b1;
    logic [AW-1:0] addr_o;
    logic wr_stb_o, rd_stb_o, mark_wr_o, eom_o, rec_led_n_o, pwr_dn_o;

    int checks = 0, errors = 0, cycles = 0;
    int wr_cnt, rd_cnt, mk_cnt, eom_cnt, last_wr, last_rd, last_mk, last_eom;

    // reference model state
    int  m_st, m_addr, m_oaddr, m_cnt;
    bit  m_wr, m_rd, m_mw, m_eom;
    bit  m_pr, m_pe, m_pl;
    bit  m_mark [D];

    always #(PERIOD/2) clk = ~clk;

    pbrec_ctrl #(.DEPTH(D), .TICK_DIV(TK)) u0 (
        .clk(clk), .rst_n(rst_n), .rec_n(rec_n),
        .play_edge_n(pe_n), .play_lvl_n(pl_n),
        .addr_o(addr_o), .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o),
        .mark_wr_o(mark_wr_o), .eom_o(eom_o),
        .rec_led_n_o(rec_led_n_o), .pwr_dn_o(pwr_dn_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // behavioural model: 0 idle, 1 recording, 2 full hold, 3 edge play, 4 level play
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_oaddr = 0; m_cnt = 0;
            m_wr = 0; m_rd = 0; m_mw = 0; m_eom = 0;
            m_pr = 1; m_pe = 1; m_pl = 1;
            for (int i = 0; i < D; i++) m_mark[i] = 0;
        end else begin
            bit fr, fe, fl, tk;
            fr = m_pr && !rec_n;
            fe = m_pe && !pe_n;
            fl = m_pl && !pl_n;
            tk = (m_cnt == TK - 1);
            m_wr = 0; m_rd = 0; m_mw = 0; m_eom = 0;
            if (fr) begin
                m_st = 1; m_addr = 0;
            end else if (m_st == 1) begin
                if (rec_n) begin
                    m_mark[m_addr] = 1; m_mw = 1; m_oaddr = m_addr; m_st = 0;
                end else if (tk) begin
                    m_mark[m_addr] = 0; m_wr = 1; m_oaddr = m_addr;
                    if (m_addr == D - 1) m_st = 2; else m_addr++;
                end
            end else if (m_st == 2) begin
                if (rec_n) m_st = 0;
            end else if (fe) begin
                m_st = 3; m_addr = 0;
            end else if (m_st == 0 && fl) begin
                m_st = 4; m_addr = 0;
            end else if (m_st == 4 && pl_n) begin
                m_st = 0;
            end else if (m_st != 0 && tk) begin
                m_rd = 1; m_oaddr = m_addr;
                if (m_mark[m_addr]) begin m_eom = 1; m_st = 0; end
                else if (m_addr == D - 1) m_st = 0;
                else m_addr++;
            end
            m_cnt = tk ? 0 : m_cnt + 1;
            m_pr = rec_n; m_pe = pe_n; m_pl = pl_n;
        end
    end

    // per-cycle comparison and event counters
    always @(negedge clk) begin
        if (rst_n) begin
            chk(addr_o == AW'(m_oaddr), "R3 addr", int'(addr_o), m_oaddr);
            chk(wr_stb_o == m_wr, "R3 wr_stb", int'(wr_stb_o), int'(m_wr));
            chk(rd_stb_o == m_rd, "R6 rd_stb", int'(rd_stb_o), int'(m_rd));
            chk(mark_wr_o == m_mw, "R4 mark_wr", int'(mark_wr_o), int'(m_mw));
            chk(eom_o == m_eom, "R8 eom", int'(eom_o), int'(m_eom));
            chk(rec_led_n_o == (m_st != 1), "R2 rec_led_n", int'(rec_led_n_o), int'(m_st != 1));
            chk(pwr_dn_o == (m_st == 0), "R7 pwr_dn", int'(pwr_dn_o), int'(m_st == 0));
            if (wr_stb_o)  begin wr_cnt++;  last_wr  = int'(addr_o); end
            if (rd_stb_o)  begin rd_cnt++;  last_rd  = int'(addr_o); end
            if (mark_wr_o) begin mk_cnt++;  last_mk  = int'(addr_o); end
            if (eom_o)     begin eom_cnt++; last_eom = int'(addr_o); end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic clr();
        wr_cnt = 0; rd_cnt = 0; mk_cnt = 0; eom_cnt = 0;
        last_wr = -1; last_rd = -1; last_mk = -1; last_eom = -1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(pwr_dn_o == 1'b1, "R1 pwr_dn", int'(pwr_dn_o), 1);
        chk(rec_led_n_o == 1'b1, "R1 rec_led_n", int'(rec_led_n_o), 1);
        chk({wr_stb_o, rd_stb_o, mark_wr_o, eom_o} == 4'b0, "R1 strobes",
            int'({wr_stb_o, rd_stb_o, mark_wr_o, eom_o}), 0);
        chk(addr_o == '0, "R1 addr", int'(addr_o), 0);

        // short record, release after five steps
        clr();
        rec_n = 1'b0;
        while (wr_cnt < 5) step();
        rec_n = 1'b1;
        step(); step();
        chk(mk_cnt == 1, "R4 marker count", mk_cnt, 1);
        chk(last_mk == 5, "R4 marker address", last_mk, 5);
        chk(pwr_dn_o == 1'b1, "R4 idle after release", int'(pwr_dn_o), 1);

        // edge play, button let go at once
        clr();
        pe_n = 1'b0; step(); pe_n = 1'b1;
        while (!pwr_dn_o) step();
        chk(rd_cnt == 6, "R8 reads to marker", rd_cnt, 6);
        chk(eom_cnt == 1 && last_eom == 5, "R8 eom at marker", last_eom, 5);

        // level play cut short
        clr();
        pl_n = 1'b0;
        while (rd_cnt < 2) step();
        pl_n = 1'b1;
        step(); step();
        chk(pwr_dn_o == 1'b1, "R7 stop on release", int'(pwr_dn_o), 1);
        chk(rd_cnt == 2, "R7 no read after release", rd_cnt, 2);

        // edge play restart
        clr();
        pe_n = 1'b0; step(); pe_n = 1'b1;
        while (rd_cnt < 3) step();
        chk(pwr_dn_o == 1'b0, "R6 release has no effect", int'(pwr_dn_o), 0);
        pe_n = 1'b0; step(); pe_n = 1'b1;
        while (rd_cnt < 4) step();
        chk(last_rd == 0, "R6 restart at zero", last_rd, 0);
        while (!pwr_dn_o) step();

        // record preempts playback, play presses ignored while recording
        clr();
        pe_n = 1'b0; step(); pe_n = 1'b1;
        while (rd_cnt < 2) step();
        rec_n = 1'b0; step();
        chk(rec_led_n_o == 1'b0, "R2 record preempts", int'(rec_led_n_o), 0);
        while (wr_cnt < 1) step();
        chk(last_wr == 0, "R2 record from zero", last_wr, 0);
        pe_n = 1'b0; step(); pe_n = 1'b1;
        pl_n = 1'b0; step(); pl_n = 1'b1;
        repeat (4) step();
        chk(rd_cnt == 2, "R9 no reads while recording", rd_cnt, 2);
        chk(rec_led_n_o == 1'b0, "R9 still recording", int'(rec_led_n_o), 0);

        // fill the space
        while (!rec_led_n_o) step();
        chk(wr_cnt == D, "R5 writes to full", wr_cnt, D);
        chk(last_wr == D - 1, "R5 last address", last_wr, D - 1);
        chk(pwr_dn_o == 1'b0, "R5 awake until release", int'(pwr_dn_o), 0);
        pe_n = 1'b0; step(); pe_n = 1'b1; step();
        chk(rd_cnt == 2 && pwr_dn_o == 1'b0, "R9 ignored while full", rd_cnt, 2);
        rec_n = 1'b1; step(); step();
        chk(mk_cnt == 0, "R5 no marker when full", mk_cnt, 0);
        chk(pwr_dn_o == 1'b1, "R5 idle after release", int'(pwr_dn_o), 1);

        // play the full space
        clr();
        pe_n = 1'b0; step(); pe_n = 1'b1;
        while (!pwr_dn_o) step();
        chk(rd_cnt == D, "R8 reads whole space", rd_cnt, D);
        chk(eom_cnt == 0 && last_rd == D - 1, "R8 ends at last address", last_rd, D - 1);

        // simultaneous presses
        clr();
        rec_n = 1'b0; pe_n = 1'b0; step();
        chk(rec_led_n_o == 1'b0, "R10 record over edge-play", int'(rec_led_n_o), 0);
        pe_n = 1'b1;
        while (wr_cnt < 3) step();
        rec_n = 1'b1; step(); step();
        chk(last_mk == 3, "R4 marker after three", last_mk, 3);
        pe_n = 1'b0; pl_n = 1'b0; step();
        pl_n = 1'b1; step();
        chk(pwr_dn_o == 1'b0, "R10 edge-play over level-play", int'(pwr_dn_o), 0);
        pe_n = 1'b1;
        while (!pwr_dn_o) step();
        chk(eom_cnt == 1 && last_eom == 3, "R8 eom at new marker", last_eom, 3);

        repeat (3) step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule